// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 64-bit processor core that fetches, executes and retires one 32-bit instruction on every clock edge. It supports six instruction kinds: load and store of a 64-bit doubleword using a base register plus a signed 9-bit offset, the register-to-register operations add, subtract, AND and OR, compare-and-branch-if-zero, and an unconditional relative branch. The core holds a 64-bit program counter and a 32 x 64-bit register file with two read ports and one write port. The instruction and data memories are separate arrays inside the block, so that a fetch and a data access can both happen in the same cycle.

Decoding takes two levels. The main decoder sorts each fetched word into one instruction class: `IC_RTYPE`, `IC_LOAD`, `IC_STORE`, `IC_CBZ`, `IC_BRANCH` or `IC_NONE`. A `unique case` over that class sets the datapath controls, among them a 2-bit ALU operation group. The second-level ALU decoder turns that group, together with the opcode for register-type words, into the ALU function. The transitions are all program-counter transitions. `SEQ` goes to PC+4 and is taken by every non-branch instruction and by a compare-and-branch whose register is non-zero. `CBZ_TAKEN` goes to PC plus the scaled 19-bit offset. `JUMP` goes to PC plus the scaled 26-bit offset.

The block has no software access path. A testbench or a boot agent fills both memories through a load port while reset is held. It then releases reset, and the core runs from address 0. The register write bus, the data write bus and the PC are brought out as a retire trace.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), the PC is cleared to 0 and every register is cleared to 0. No register write and no data memory write is performed while `rst` is high.
- R2: At each rising edge with `ld_en` high, `ld_data` is written to word `ld_addr` of the instruction memory when `ld_sel` is 0 (using the low 32 bits), or of the data memory when `ld_sel` is 1.
- R3: Load (bits 31:21 = 11111000010) writes `dmem[(X[Rn] + sext(bits 20:12)) >> 3]` to register Rt. Rn is bits 9:5 and Rt is bits 4:0.
- R4: Store (bits 31:21 = 11111000000) writes X[Rt] to data memory at byte address X[Rn] + sext(bits 20:12), in doubleword granules (address bits above bit 2). It performs no register write.
- R5: Register-type operations write to Rd (bits 4:0) the result of X[Rn] op X[Rm], where Rm is bits 20:16. The opcodes in bits 31:21 are ADD 10001011000, SUB 11001011000, AND 10001010000 and ORR 10101010000.
- R6: Register 31 always reads as zero, and writes to it are ignored.
- R7: Compare-and-branch (bits 31:24 = 10110100) tests X[Rt], with Rt in bits 4:0. If X[Rt] is zero, the next PC is PC + sext(bits 23:5)*4. Otherwise the next PC is PC+4. It performs no register or memory write.
- R8: The unconditional branch (bits 31:26 = 000101) sets the next PC to PC + sext(bits 25:0)*4. This includes a negative offset and an offset of zero (a self-loop). It performs no write.
- R9: Any other instruction word writes nothing and advances the PC by 4.
- R10: Every non-branch instruction retires in exactly one cycle and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write enable |
| ld_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | XLEN | Preload data (low 32 bits used for instructions) |
| pc_o | output | XLEN | Current program counter |
| rf_we_o | output | 1 | Register write in this cycle |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | XLEN | Register write value |
| dm_we_o | output | 1 | Data memory write in this cycle |
| dm_addr_o | output | XLEN | Data byte address computed by the ALU |
| dm_wdata_o | output | XLEN | Data memory write value |

## Verification
A single program drives the core. It loads three distinct operand patterns, including one with high bits set, and then puts them through all four ALU operations. For AND and OR, the operands are chosen so that the two results differ in their low bits. Addressing is tried with a zero base, a positive offset and a negative offset, which separates correct sign extension of the 9-bit field from zero extension. A store followed by a load from the same address shows that the write has landed. Branches are exercised as compare-and-branch both taken and not taken, and as forward, backward and zero-offset jumps; the skipped words would produce visible writes if they were executed. A write to register 31 followed by a read of it tells a true zero register apart from an ordinary one. A behavioural model in the bench compares the PC and both write buses on every clock.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [2:0] {
        IC_NONE,
        IC_RTYPE,
        IC_LOAD,
        IC_STORE,
        IC_CBZ,
        IC_BRANCH
    } iclass_e;

    typedef enum logic [3:0] {
        FN_AND  = 4'b0000,
        FN_OR   = 4'b0001,
        FN_ADD  = 4'b0010,
        FN_SUB  = 4'b0110,
        FN_PASS = 4'b0111
    } alu_fn_e;

    typedef enum logic [1:0] {
        GRP_ADD   = 2'b00,
        GRP_PASSB = 2'b01,
        GRP_FIELD = 2'b10
    } alu_grp_e;

    typedef struct packed {
        logic     rt_as_src2;
        logic     use_imm;
        logic     wb_from_mem;
        logic     reg_write;
        logic     mem_write;
        logic     cond_branch;
        logic     jump;
        alu_grp_e grp;
    } ctl_t;

    localparam logic [10:0] OPC_LOAD  = 11'b11111000010;
    localparam logic [10:0] OPC_STORE = 11'b11111000000;
    localparam logic [10:0] OPC_ADD   = 11'b10001011000;
    localparam logic [10:0] OPC_SUB   = 11'b11001011000;
    localparam logic [10:0] OPC_AND   = 11'b10001010000;
    localparam logic [10:0] OPC_ORR   = 11'b10101010000;
    localparam logic [7:0]  OPC_CBZ   = 8'b10110100;
    localparam logic [5:0]  OPC_B     = 6'b000101;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [31:0] instr,
    output iclass_e     cls,
    output ctl_t        ctl,
    output alu_fn_e     fn
);

    logic [10:0] opc;
    assign opc = instr[31:21];

    // first level: instruction class
    always_comb begin
        if (opc == OPC_LOAD)
            cls = IC_LOAD;
        else if (opc == OPC_STORE)
            cls = IC_STORE;
        else if (opc == OPC_ADD || opc == OPC_SUB || opc == OPC_AND || opc == OPC_ORR)
            cls = IC_RTYPE;
        else if (instr[31:24] == OPC_CBZ)
            cls = IC_CBZ;
        else if (instr[31:26] == OPC_B)
            cls = IC_BRANCH;
        else
            cls = IC_NONE;
    end

    // main control outputs per class
    always_comb begin
        ctl = '0;
        ctl.grp = GRP_ADD;
        unique case (cls)
            IC_RTYPE: begin
                ctl.reg_write = 1'b1;
                ctl.grp       = GRP_FIELD;
            end
            IC_LOAD: begin
                ctl.use_imm     = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.reg_write   = 1'b1;
            end
            IC_STORE: begin
                ctl.rt_as_src2 = 1'b1;
                ctl.use_imm    = 1'b1;
                ctl.mem_write  = 1'b1;
            end
            IC_CBZ: begin
                ctl.rt_as_src2  = 1'b1;
                ctl.cond_branch = 1'b1;
                ctl.grp         = GRP_PASSB;
            end
            IC_BRANCH: begin
                ctl.jump = 1'b1;
            end
            IC_NONE: begin
                ctl.grp = GRP_ADD;
            end
            default: begin
                ctl.grp = GRP_ADD;
            end
        endcase
    end

    // second level: ALU function
    always_comb begin
        fn = FN_ADD;
        unique case (ctl.grp)
            GRP_ADD:   fn = FN_ADD;
            GRP_PASSB: fn = FN_PASS;
            GRP_FIELD: begin
                if (opc == OPC_SUB)      fn = FN_SUB;
                else if (opc == OPC_AND) fn = FN_AND;
                else if (opc == OPC_ORR) fn = FN_OR;
                else                     fn = FN_ADD;
            end
            default: fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (fn)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_PASS: y = b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W = 64,
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] waddr,
    input  logic [W-1:0]         wdata,
    input  logic [$clog2(N)-1:0] ra1,
    input  logic [$clog2(N)-1:0] ra2,
    output logic [W-1:0]         rd1,
    output logic [W-1:0]         rd2
);

    localparam int AW = $clog2(N);
    localparam logic [AW-1:0] ZR = AW'(N - 1);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && waddr != ZR) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1 = (ra1 == ZR) ? '0 : regs[ra1];
    assign rd2 = (ra2 == ZR) ? '0 : regs[ra2];

    assert_zero_reg_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we && waddr == ZR) && ra1 == ZR) |-> rd1 == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int LD_AW      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    output logic [XLEN-1:0]  pc_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic             dm_we_o,
    output logic [XLEN-1:0]  dm_addr_o,
    output logic [XLEN-1:0]  dm_wdata_o
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] pc_q, pc_next;
    logic [31:0]     imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];
    logic [31:0]     instr;

    iclass_e         cls;
    ctl_t            ctl;
    alu_fn_e         fn;
    logic [4:0]      ra2;
    logic [XLEN-1:0] rd1, rd2, imm, alu_b, alu_y, dm_rdata, wb_data;
    logic [XLEN-1:0] cbz_off, jmp_off;
    logic            alu_zero, rf_we, dm_we;

    // program counter
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    // instruction memory: preload write, asynchronous fetch
    always_ff @(posedge clk) begin
        if (ld_en && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data[31:0];
    end
    assign instr = imem[pc_q[IAW+1:2]];

    sc_decode u_dec (
        .instr (instr),
        .cls   (cls),
        .ctl   (ctl),
        .fn    (fn)
    );

    assign ra2 = ctl.rt_as_src2 ? instr[4:0] : instr[20:16];
    assign rf_we = ctl.reg_write && !rst;

    sc_regfile #(.W(XLEN), .N(32)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (instr[4:0]),
        .wdata (wb_data),
        .ra1   (instr[9:5]),
        .ra2   (ra2),
        .rd1   (rd1),
        .rd2   (rd2)
    );

    assign imm   = {{(XLEN-9){instr[20]}}, instr[20:12]};
    assign alu_b = ctl.use_imm ? imm : rd2;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rd1),
        .b    (alu_b),
        .fn   (fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: synchronous write, asynchronous read
    assign dm_we = ctl.mem_write && !rst;
    always_ff @(posedge clk) begin
        if (ld_en && ld_sel)
            dmem[ld_addr[DAW-1:0]] <= ld_data;
        else if (dm_we)
            dmem[alu_y[DAW+2:3]] <= rd2;
    end
    assign dm_rdata = dmem[alu_y[DAW+2:3]];
    assign wb_data  = ctl.wb_from_mem ? dm_rdata : alu_y;

    // next PC
    assign cbz_off = {{(XLEN-21){instr[23]}}, instr[23:5], 2'b00};
    assign jmp_off = {{(XLEN-28){instr[25]}}, instr[25:0], 2'b00};

    always_comb begin
        if (ctl.jump)
            pc_next = pc_q + jmp_off;
        else if (ctl.cond_branch && alu_zero)
            pc_next = pc_q + cbz_off;
        else
            pc_next = pc_q + XLEN'(4);
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = instr[4:0];
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd2;

    assert_reset_pc_R1: assert property (@(posedge clk)
        $past(rst) |-> pc_q == '0);

    assert_seq_advance_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!ctl.jump && !ctl.cond_branch)) |-> pc_q == $past(pc_q) + XLEN'(4));

    assert_cbz_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl.cond_branch && rd2 == '0)) |-> pc_q == $past(pc_q + cbz_off));

    assert_store_no_regwrite_R4: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> !rf_we);

endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;

    localparam int XLEN = 64;
    localparam int LD_AW = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             ld_en, ld_sel;
    logic [LD_AW-1:0] ld_addr;
    logic [XLEN-1:0]  ld_data;
    logic [XLEN-1:0]  pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic             rf_we_o, dm_we_o;
    logic [4:0]       rf_waddr_o;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit          done  = 1'b0;

    always #2.5 clk = ~clk;

    sc_core #(.XLEN(XLEN), .LD_AW(LD_AW)) i_sc_core (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    // reference state
    logic [31:0]     m_imem [64];
    logic [XLEN-1:0] m_dmem [64];
    logic [XLEN-1:0] m_reg  [32];
    logic [XLEN-1:0] m_pc;

    function automatic logic [31:0] e_r(input logic [10:0] op, input int rm, input int rn, input int rd);
        return {op, 5'(rm), 6'b0, 5'(rn), 5'(rd)};
    endfunction
    function automatic logic [31:0] e_d(input logic [10:0] op, input logic [8:0] off, input int rn, input int rt);
        return {op, off, 2'b00, 5'(rn), 5'(rt)};
    endfunction
    function automatic logic [31:0] e_cbz(input logic [18:0] off, input int rt);
        return {8'b10110100, off, 5'(rt)};
    endfunction
    function automatic logic [31:0] e_b(input logic [25:0] off);
        return {6'b000101, off};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] rdreg(input logic [4:0] r);
        return (r == 5'd31) ? '0 : m_reg[r];
    endfunction

    // compare the design with the model for the current cycle, then step the model
    task automatic step_and_compare();
        logic [31:0]     w;
        logic [10:0]     op;
        logic [XLEN-1:0] a, ea, res, nxt;
        logic            e_rwe, e_dwe;
        w = m_imem[m_pc[7:2]];
        op = w[31:21];
        e_rwe = 1'b0; e_dwe = 1'b0; res = '0; ea = '0;
        nxt = m_pc + 64'd4;
        a = rdreg(w[9:5]);
        ea = a + {{55{w[20]}}, w[20:12]};
        if (op == 11'b11111000010) begin
            e_rwe = 1'b1; res = m_dmem[ea[8:3]];
        end else if (op == 11'b11111000000) begin
            e_dwe = 1'b1;
        end else if (op == 11'b10001011000) begin
            e_rwe = 1'b1; res = a + rdreg(w[20:16]);
        end else if (op == 11'b11001011000) begin
            e_rwe = 1'b1; res = a - rdreg(w[20:16]);
        end else if (op == 11'b10001010000) begin
            e_rwe = 1'b1; res = a & rdreg(w[20:16]);
        end else if (op == 11'b10101010000) begin
            e_rwe = 1'b1; res = a | rdreg(w[20:16]);
        end else if (w[31:24] == 8'b10110100) begin
            if (rdreg(w[4:0]) == '0) nxt = m_pc + {{43{w[23]}}, w[23:5], 2'b00};
        end else if (w[31:26] == 6'b000101) begin
            nxt = m_pc + {{36{w[25]}}, w[25:0], 2'b00};
        end

        check(pc_o == m_pc, "R10 pc", pc_o, m_pc);
        check(rf_we_o == e_rwe, "R9 reg write enable", 64'(rf_we_o), 64'(e_rwe));
        check(dm_we_o == e_dwe, "R4 mem write enable", 64'(dm_we_o), 64'(e_dwe));
        if (e_rwe) begin
            check(rf_waddr_o == w[4:0], "R5 write index", 64'(rf_waddr_o), 64'(w[4:0]));
            check(rf_wdata_o == res, "R5 write data", rf_wdata_o, res);
        end
        if (e_dwe) begin
            check(dm_addr_o == ea, "R4 store address", dm_addr_o, ea);
            check(dm_wdata_o == rdreg(w[4:0]), "R4 store data", dm_wdata_o, rdreg(w[4:0]));
        end

        // directed expectations per program word
        case (m_pc[7:2])
            6'd0:  check(rf_wdata_o == 64'd0, "R1 registers cleared", rf_wdata_o, 64'd0);
            6'd1:  check(rf_wdata_o == 64'd5, "R3 load zero offset", rf_wdata_o, 64'd5);
            6'd3:  check(rf_wdata_o == 64'hF0F0_0000_0000_00F3, "R2 data preload", rf_wdata_o, 64'hF0F0_0000_0000_00F3);
            6'd4:  check(rf_wdata_o == 64'd12, "R5 add", rf_wdata_o, 64'd12);
            6'd5:  check(rf_wdata_o == 64'hFFFF_FFFF_FFFF_FFFE, "R5 sub", rf_wdata_o, 64'hFFFF_FFFF_FFFF_FFFE);
            6'd6:  check(rf_wdata_o == 64'd3, "R5 and", rf_wdata_o, 64'd3);
            6'd7:  check(rf_wdata_o == 64'hF0F0_0000_0000_00F7, "R5 orr", rf_wdata_o, 64'hF0F0_0000_0000_00F7);
            6'd8:  check(dm_we_o && dm_addr_o == 64'd24 && dm_wdata_o == 64'd12, "R4 store", dm_wdata_o, 64'd12);
            6'd10: check(rf_wdata_o == 64'd5, "R6 zero register read", rf_wdata_o, 64'd5);
            6'd11: check(rf_wdata_o == 64'd7, "R3 negative offset", rf_wdata_o, 64'd7);
            6'd12: check(nxt == 64'd52, "R7 not taken", nxt, 64'd52);
            6'd13: check(nxt == 64'd60, "R7 taken", nxt, 64'd60);
            6'd15: check(nxt == 64'd72, "R8 forward", nxt, 64'd72);
            6'd21: check(rf_wdata_o == 64'd2, "R4 store then load", rf_wdata_o, 64'd2);
            6'd22: check(nxt == 64'd88, "R8 zero offset", nxt, 64'd88);
            6'd23: check(!rf_we_o && !dm_we_o, "R9 unknown word", 64'(rf_we_o), 64'd0);
            6'd24: check(nxt == 64'd80, "R8 backward", nxt, 64'd80);
            default: ;
        endcase

        if (e_rwe && w[4:0] != 5'd31) m_reg[w[4:0]] = res;
        if (e_dwe) m_dmem[ea[8:3]] = rdreg(w[4:0]);
        m_pc = nxt;
    endtask

    task automatic load_word(input bit sel, input int idx, input logic [XLEN-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_addr = LD_AW'(idx); ld_data = d;
    endtask

    initial begin
        rst = 1'b1; ld_en = 1'b0; ld_sel = 1'b0; ld_addr = '0; ld_data = '0;
        for (int i = 0; i < 64; i++) begin m_imem[i] = 32'h0; m_dmem[i] = '0; end
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_pc = '0;

        m_imem[0]  = e_r(11'b10001011000, 2, 1, 14);
        m_imem[1]  = e_d(11'b11111000010, 9'd0, 31, 1);
        m_imem[2]  = e_d(11'b11111000010, 9'd8, 31, 2);
        m_imem[3]  = e_d(11'b11111000010, 9'd16, 31, 3);
        m_imem[4]  = e_r(11'b10001011000, 2, 1, 4);
        m_imem[5]  = e_r(11'b11001011000, 2, 1, 5);
        m_imem[6]  = e_r(11'b10001010000, 2, 3, 6);
        m_imem[7]  = e_r(11'b10101010000, 1, 3, 7);
        m_imem[8]  = e_d(11'b11111000000, 9'd24, 31, 4);
        m_imem[9]  = e_r(11'b10001011000, 2, 1, 31);
        m_imem[10] = e_r(11'b10001011000, 1, 31, 8);
        m_imem[11] = e_d(11'b11111000010, 9'h1FC, 4, 9);
        m_imem[12] = e_cbz(19'd3, 1);
        m_imem[13] = e_cbz(19'd2, 31);
        m_imem[14] = e_r(11'b10001011000, 1, 1, 10);
        m_imem[15] = e_b(26'd3);
        m_imem[16] = e_r(11'b10001011000, 1, 1, 11);
        m_imem[17] = e_r(11'b10001011000, 1, 1, 11);
        m_imem[18] = e_r(11'b11001011000, 1, 2, 12);
        m_imem[19] = e_b(26'd4);
        m_imem[20] = e_d(11'b11111000000, 9'h1FC, 4, 12);
        m_imem[21] = e_d(11'b11111000010, 9'd8, 31, 13);
        m_imem[22] = e_b(26'd0);
        m_imem[23] = 32'h0000_0000;
        m_imem[24] = e_b(26'h3FF_FFFC);
        m_dmem[0] = 64'd5;
        m_dmem[1] = 64'd7;
        m_dmem[2] = 64'hF0F0_0000_0000_00F3;

        repeat (2) @(negedge clk);
        for (int i = 0; i < 64; i++) load_word(1'b0, i, {32'h0, m_imem[i]});
        for (int i = 0; i < 4; i++)  load_word(1'b1, i, m_dmem[i]);
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        #1;
        check(pc_o == '0, "R1 reset pc", pc_o, '0);
        check(!rf_we_o && !dm_we_o, "R1 no writes in reset", 64'(rf_we_o), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 40; c++) begin
            #1;
            step_and_compare();
            @(negedge clk);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R10 actual=%h expected=%h", pc_o, m_pc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule